// File: doc/BRIEF.md
# Ring-Oscillator Phase Decoder for Time Stamping

This block turns a captured snapshot of a free-running inverting ring oscillator into a binary time stamp. The ring has sixteen stages. Because the loop inverts, one oscillation period passes through thirty-two distinct stage patterns. First the stages fill with ones starting at stage 0, and then they empty again starting at stage 0. The decoder receives the latched stage bits and a latched coarse count, taken by the same hit. It turns the pattern into a 5-bit fine phase and joins it with the coarse count to form the time stamp.

The coarse counter is clocked by the ring and advances twice per period: once when the ring reaches the all-zero pattern and once when it reaches the all-one pattern. Its least significant bit therefore states which half of the period the ring was in. The fine phase carries that same information in its top bit. When the two disagree, the counter was caught on the wrong side of its own edge. The decoder then moves the count by one toward the fine phase before it drops the redundant bit.

Latches that resolve late can leave isolated wrong bits, called bubbles, in the pattern. The decoder smooths every pattern by a three-bit majority before it decodes it, and it raises an error flag for any pattern with more than one transition. Captures enter through a valid/ready input. Results leave through a one-entry valid/ready output register, one cycle after capture. A stalled output holds its data and blocks new captures until the result is taken.

Top module: `ring_tdc_decoder`

## Requirements
- R1: `cap_ready` is high exactly when the output register is empty or `ts_ready` is high. A capture happens on a rising clock edge with `cap_valid` and `cap_ready` both high; when `cap_ready` is low, the presented stage and coarse values are not taken.
- R2: After a capture, `ts_valid` is high in the next cycle with that capture's result. While `ts_valid` is high and `ts_ready` is low, `ts_valid`, `ts_stamp` and `ts_bubble` do not change.
- R3: A stage pattern whose bit 0 is 1, with k consecutive ones starting at bit 0 (1 ≤ k ≤ 16) and zeros above them, gives fine phase k. The all-ones pattern gives 16.
- R4: A pattern with k consecutive zeros starting at bit 0 (1 ≤ k ≤ 15) and ones above them gives fine phase 16+k. The all-zeros pattern gives fine phase 0.
- R5: `ts_stamp` is {H[COARSE_W-1:1], fine}, with the fine phase in bits [4:0] and H the aligned half-period count. When coarse bit 0 equals fine bit 4, H is the captured coarse value.
- R6: When coarse bit 0 differs from fine bit 4 and fine bits [3:0] are below 8, H is the coarse value plus one, modulo 2^COARSE_W.
- R7: When coarse bit 0 differs from fine bit 4 and fine bits [3:0] are 8 or more, H is the coarse value minus one, modulo 2^COARSE_W.
- R8: `ts_bubble` is 1 when the captured pattern has more than one place where adjacent stage bits differ, and 0 otherwise.
- R9: Before decoding, each inner stage bit i (1..14) is replaced by the majority of bits i-1, i, i+1. Bits 0 and 15 are kept. The fine phase comes from the length of the leading run of the smoothed pattern, by the rules of R3 and R4.
- R10: After reset, `ts_valid` and `ts_bubble` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_valid | input | 1 | Capture request carrying latched stage and coarse values |
| cap_ready | output | 1 | Decoder can take a capture this cycle |
| cap_stages | input | N_STAGES | Latched ring stage outputs, bit 0 is the first stage |
| cap_coarse | input | COARSE_W | Latched half-period coarse count |
| ts_valid | output | 1 | Time stamp is present |
| ts_ready | input | 1 | Consumer takes the time stamp |
| ts_stamp | output | COARSE_W-1+5 | Aligned time stamp, fine phase in low 5 bits |
| ts_bubble | output | 1 | Captured pattern had more than one transition |

## Verification
A fault in the run-length decode or in the majority smoothing shows up as a wrong low field of `ts_stamp` in the cycle after the capture. A sweep of all 32 ring phases reaches every leading-run length. A wrong alignment decision shows in the upper field of the same output word, and only when the coarse parity disagrees with the fine half. Both the increment and the decrement case are therefore driven directly, including a wrap at each end of the count. A broken output register shows as a changed stamp during a stall, or as a capture that is lost or duplicated once the stall is released.

// File: rtl/ring_tdc_pkg.sv
package ring_tdc_pkg;
  // Fine phase width for a ring of n stages with loop inversion (2n phases).
  function automatic int fine_width(input int n);
    return $clog2(2 * n);
  endfunction
endpackage

// File: rtl/ring_tdc_smoother.sv
module ring_tdc_smoother #(
  parameter int N_STAGES = 16
) (
  input  logic [N_STAGES-1:0] raw,
  output logic [N_STAGES-1:0] smooth,
  output logic                bubble
);
  localparam int CNT_W = $clog2(N_STAGES);

  logic [N_STAGES-2:0] edges;
  assign edges = raw[N_STAGES-1:1] ^ raw[N_STAGES-2:0];

  // Edge stages have only one neighbour; they pass through.
  assign smooth[0]          = raw[0];
  assign smooth[N_STAGES-1] = raw[N_STAGES-1];

  generate
    for (genvar i = 1; i < N_STAGES - 1; i++) begin : g_maj
      assign smooth[i] = (raw[i-1] & raw[i]) | (raw[i] & raw[i+1]) |
                         (raw[i-1] & raw[i+1]);
    end
  endgenerate

  logic [CNT_W-1:0] n_edges;
  always_comb begin
    n_edges = '0;
    for (int i = 0; i < N_STAGES - 1; i++) begin
      n_edges = n_edges + CNT_W'(edges[i]);
    end
  end

  assign bubble = (n_edges > CNT_W'(1));
endmodule

// File: rtl/ring_tdc_phase.sv
module ring_tdc_phase #(
  parameter int N_STAGES = 16,
  parameter int FINE_W   = 5
) (
  input  logic [N_STAGES-1:0] pattern,
  output logic [FINE_W-1:0]   fine
);
  localparam int RUN_W = $clog2(N_STAGES + 1);

  logic [RUN_W-1:0] run;
  logic             open;

  // Length of the leading run of bits equal to bit 0.
  always_comb begin
    run  = '0;
    open = 1'b1;
    for (int i = 0; i < N_STAGES; i++) begin
      if (open && (pattern[i] == pattern[0])) begin
        run = run + RUN_W'(1);
      end else begin
        open = 1'b0;
      end
    end
  end

  always_comb begin
    if (pattern[0]) begin
      fine = FINE_W'(run);
    end else if (run == RUN_W'(N_STAGES)) begin
      fine = '0;
    end else begin
      fine = FINE_W'(N_STAGES) + FINE_W'(run);
    end
  end
endmodule

// File: rtl/ring_tdc_align.sv
module ring_tdc_align #(
  parameter int COARSE_W = 10,
  parameter int FINE_W   = 5,
  parameter int TS_W     = COARSE_W - 1 + FINE_W
) (
  input  logic [COARSE_W-1:0] coarse,
  input  logic [FINE_W-1:0]   fine,
  output logic [COARSE_W-1:0] half_cnt,
  output logic [TS_W-1:0]     stamp
);
  logic mismatch;
  logic early_in_half;

  assign mismatch      = coarse[0] ^ fine[FINE_W-1];
  assign early_in_half = ~fine[FINE_W-2];

  always_comb begin
    if (!mismatch) begin
      half_cnt = coarse;
    end else if (early_in_half) begin
      half_cnt = coarse + COARSE_W'(1);
    end else begin
      half_cnt = coarse - COARSE_W'(1);
    end
  end

  assign stamp = {half_cnt[COARSE_W-1:1], fine};
endmodule

// File: rtl/ring_tdc_decoder.sv
module ring_tdc_decoder #(
  parameter int N_STAGES = 16,
  parameter int COARSE_W = 10,
  parameter int FINE_W   = 5,
  parameter int TS_W     = COARSE_W - 1 + FINE_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cap_valid,
  output logic                cap_ready,
  input  logic [N_STAGES-1:0] cap_stages,
  input  logic [COARSE_W-1:0] cap_coarse,
  output logic                ts_valid,
  input  logic                ts_ready,
  output logic [TS_W-1:0]     ts_stamp,
  output logic                ts_bubble
);
  logic [N_STAGES-1:0] smooth;
  logic                bubble;
  logic [FINE_W-1:0]   fine;
  logic [COARSE_W-1:0] half_cnt;
  logic [TS_W-1:0]     stamp;
  logic                take;

  ring_tdc_smoother #(.N_STAGES(N_STAGES)) u_smooth (
    .raw(cap_stages), .smooth(smooth), .bubble(bubble)
  );

  ring_tdc_phase #(.N_STAGES(N_STAGES), .FINE_W(FINE_W)) u_phase (
    .pattern(smooth), .fine(fine)
  );

  ring_tdc_align #(.COARSE_W(COARSE_W), .FINE_W(FINE_W), .TS_W(TS_W)) u_align (
    .coarse(cap_coarse), .fine(fine), .half_cnt(half_cnt), .stamp(stamp)
  );

  assign cap_ready = ~ts_valid | ts_ready;
  assign take      = cap_valid & cap_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ts_valid  <= 1'b0;
      ts_stamp  <= '0;
      ts_bubble <= 1'b0;
    end else if (take) begin
      ts_valid  <= 1'b1;
      ts_stamp  <= stamp;
      ts_bubble <= bubble;
    end else if (ts_ready) begin
      ts_valid  <= 1'b0;
    end
  end

  assert_capture_shows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> ts_valid);

  assert_stall_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ts_valid && !ts_ready) |=> (ts_valid && $stable(ts_stamp) && $stable(ts_bubble)));

  assert_stall_blocks_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ts_valid && !ts_ready && !cap_valid) |=> $stable(ts_stamp));

  assert_clean_unsmoothed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !bubble) |-> (smooth == cap_stages));

  assert_zero_run_half_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !bubble && !cap_stages[0] && (cap_stages != '0)) |-> fine[FINE_W-1]);

  assert_parity_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (cap_coarse[0] == fine[FINE_W-1])) |-> (half_cnt == cap_coarse));

  assert_flat_no_bubble_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (cap_stages == '0)) |=> !ts_bubble);
endmodule

// File: tb/tb_ring_tdc_decoder.sv
module tb_ring_tdc_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 16;
  localparam int CW = 10;
  localparam int TW = CW - 1 + 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cap_valid = 1'b0;
  logic          cap_ready;
  logic [NS-1:0] cap_stages = '0;
  logic [CW-1:0] cap_coarse = '0;
  logic          ts_valid;
  logic          ts_ready = 1'b1;
  logic [TW-1:0] ts_stamp;
  logic          ts_bubble;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ring_tdc_decoder #(.N_STAGES(NS), .COARSE_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .cap_valid(cap_valid), .cap_ready(cap_ready),
    .cap_stages(cap_stages), .cap_coarse(cap_coarse), .ts_valid(ts_valid),
    .ts_ready(ts_ready), .ts_stamp(ts_stamp), .ts_bubble(ts_bubble)
  );

  function automatic logic [NS-1:0] ring_state(input int p);
    logic [NS-1:0] s;
    for (int i = 0; i < NS; i++) begin
      if (p <= NS) s[i] = (i < p);
      else         s[i] = (i >= p - NS);
    end
    return s;
  endfunction

  function automatic bit model_bubble(input logic [NS-1:0] s);
    int t = 0;
    for (int i = 1; i < NS; i++) if (s[i] != s[i-1]) t++;
    return t > 1;
  endfunction

  function automatic int model_fine(input logic [NS-1:0] s);
    logic [NS-1:0] m;
    int run = 0;
    m = s;
    for (int i = 1; i < NS - 1; i++)
      m[i] = (s[i-1] + s[i] + s[i+1]) >= 2;
    while (run < NS && m[run] == m[0]) run++;
    if (m[0]) return run;
    if (run == NS) return 0;
    return NS + run;
  endfunction

  function automatic logic [TW-1:0] model_stamp(input logic [NS-1:0] s, input int c);
    int f = model_fine(s);
    int h = c;
    if ((c % 2) != (f / 16)) h = ((f % 16) < 8) ? c + 1 : c - 1;
    h = (h + (1 << CW)) % (1 << CW);
    return TW'(((h / 2) << 5) | f);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Present one capture with the consumer ready, check the result next cycle.
  task automatic capture_and_check(input string req, input logic [NS-1:0] s, input int c);
    @(negedge clk);
    cap_stages = s;
    cap_coarse = CW'(c);
    cap_valid  = 1'b1;
    @(negedge clk);
    cap_valid = 1'b0;
    check({req, " valid"}, 32'(ts_valid), 32'd1);
    check({req, " stamp"}, 32'(ts_stamp), 32'(model_stamp(s, c)));
    check({req, " bubble"}, 32'(ts_bubble), 32'(model_bubble(s)));
  endtask

  task automatic test_reset();
    check("R10 valid after reset", 32'(ts_valid), 32'd0);
    check("R10 bubble after reset", 32'(ts_bubble), 32'd0);
    check("R1 ready after reset", 32'(cap_ready), 32'd1);
  endtask

  task automatic test_phase_sweep();
    for (int p = 0; p < 2 * NS; p++) begin
      int c = 2 * (p + 3) + ((p >= NS) ? 1 : 0);
      capture_and_check((p <= NS) ? "R3 R5 ones run" : "R4 R5 zeros run", ring_state(p), c);
      check("R3 R4 fine field", 32'(ts_stamp[4:0]), 32'(p));
    end
  endtask

  task automatic test_align();
    capture_and_check("R6 late coarse", ring_state(2), 5);
    check("R6 upper", 32'(ts_stamp[TW-1:5]), 32'd3);
    capture_and_check("R6 wrap up", ring_state(1), 1023);
    check("R6 wrap upper", 32'(ts_stamp[TW-1:5]), 32'd0);
    capture_and_check("R7 early coarse", ring_state(14), 5);
    check("R7 upper", 32'(ts_stamp[TW-1:5]), 32'd2);
    capture_and_check("R7 wrap down", ring_state(31), 0);
    check("R7 wrap upper", 32'(ts_stamp[TW-1:5]), 32'd511);
    capture_and_check("R6 second half", ring_state(18), 8);
    check("R6 second half upper", 32'(ts_stamp[TW-1:5]), 32'd4);
  endtask

  task automatic test_bubbles();
    capture_and_check("R8 R9 hole in ones", 16'h0037, 4);
    check("R9 repaired fine", 32'(ts_stamp[4:0]), 32'd6);
    check("R8 flag set", 32'(ts_bubble), 32'd1);
    capture_and_check("R8 R9 spike in zeros", 16'hFF08, 3);
    check("R9 spike fine", 32'(ts_stamp[4:0]), 32'd24);
    capture_and_check("R8 R9 edge bit", 16'h00F1, 4);
    capture_and_check("R8 clean clears", ring_state(9), 2);
    check("R8 flag clear", 32'(ts_bubble), 32'd0);
  endtask

  task automatic test_backpressure();
    logic [TW-1:0] first_exp;
    logic [TW-1:0] second_exp;
    first_exp  = model_stamp(ring_state(5), 12);
    second_exp = model_stamp(ring_state(20), 13);
    @(negedge clk);
    ts_ready   = 1'b0;
    cap_stages = ring_state(5);
    cap_coarse = CW'(12);
    cap_valid  = 1'b1;
    @(negedge clk);
    cap_stages = ring_state(20);
    cap_coarse = CW'(13);
    check("R1 ready low when full", 32'(cap_ready), 32'd0);
    check("R2 first result", 32'(ts_stamp), 32'(first_exp));
    @(negedge clk);
    check("R2 held valid", 32'(ts_valid), 32'd1);
    check("R1 R2 held stamp", 32'(ts_stamp), 32'(first_exp));
    ts_ready = 1'b1;
    #1;
    check("R1 ready with consumer", 32'(cap_ready), 32'd1);
    @(negedge clk);
    cap_valid = 1'b0;
    check("R2 second result", 32'(ts_stamp), 32'(second_exp));
    check("R2 second valid", 32'(ts_valid), 32'd1);
    @(negedge clk);
    check("R2 drained", 32'(ts_valid), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_phase_sweep();
    test_align();
    test_bubbles();
    test_backpressure();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule